// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM Model

This block is a synthesizable model of a synchronous static RAM whose data bus never needs an idle cycle between reads and writes. Address, control and byte-lane strobes are sampled on a rising clock edge. The data belonging to that command moves two enabled edges later. For a read, the word is registered onto the output at that edge. For a write, the input word is sampled and stored at that edge. Because every command has the same fixed data slot, reads and writes can be issued in any mix on consecutive cycles.

A four-beat burst engine lets one loaded address serve four consecutive transfers. The beats advance in either linear or interleaved order. The order is chosen by a static pin. Three chip enables qualify each load. A clock enable freezes the whole block. An asynchronous output enable can gate the bus driver at any time. The bidirectional 36-bit bus is split into separate input, output and drive-enable signals. The memory depth is a parameter.

Top module: `pipe_sram_zt`

## Requirements
- R1: A read command sampled at enabled edge N drives `dq_oe_o` high and presents the stored word on `dq_o` from enabled edge N+2 until the next enabled edge.
- R2: For a write command sampled at enabled edge N, `dq_i` is sampled at enabled edge N+2. Lane k (bits 9k+8 down to 9k) is stored only if `bw_n_i[k]` was 0 at edge N. The other lanes keep their old contents.
- R3: Reads and writes can be issued on every consecutive enabled cycle with no idle slot. A read issued two cycles after a write to the same address returns the newly written lanes.
- R4: `dq_oe_o` is low after enabled edge N+2 when the command at edge N was a write or a deselect.
- R5: While `oe_n_i` is 1, `dq_oe_o` is 0 at once, without waiting for a clock. Pipeline contents are unaffected, so the data reappears when `oe_n_i` returns to 0.
- R6: While `cke_n_i` is 1, the clock edge is ignored. No input is sampled and all state holds, including the burst state, the pipeline and the outputs. Pending transfers resume at the next enabled edge.
- R7: A load cycle (`adv_i`=0) starts an operation only when the device is selected: `sel_a_n_i`=0, `sel_b_i`=1 and `sel_c_n_i`=0. Any other load cycle starts nothing and ends a running burst, but transfers already in the pipeline still complete.
- R8: An advance cycle (`adv_i`=1) during an active burst issues the next beat. It uses the direction of the load cycle and ignores `addr_i`, `rw_i` and the chip enables. The two low address bits step through a 4-beat sequence that wraps, while the upper bits stay fixed.
- R9: With `burst_lin_i`=1, beat n of a burst loaded at low bits a uses (a+n) mod 4. With `burst_lin_i`=0, it uses a XOR n.
- R10: An advance cycle with no active burst (after reset or after a deselecting load) starts no operation.
- R11: While `rst_n` is 0 at a clock edge, the pipeline empties, the burst ends and `dq_oe_o` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_n_i | input | 1 | Clock enable, active low; 1 stalls the block |
| adv_i | input | 1 | 0 loads a new address, 1 advances the burst |
| rw_i | input | 1 | 1 read, 0 write (sampled on load cycles) |
| addr_i | input | AW | Word address |
| sel_a_n_i | input | 1 | Chip enable, active low |
| sel_b_i | input | 1 | Chip enable, active high |
| sel_c_n_i | input | 1 | Chip enable, active low |
| bw_n_i | input | LANES | Byte-lane write strobes, active low |
| burst_lin_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| dq_i | input | LANES*LANE_W | Write data |
| dq_o | output | LANES*LANE_W | Read data |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
Each command's data slot is due two enabled edges after it is sampled, and every stalled edge pushes it back by one. Output enable acts in the same cycle. The bench keeps a step model that advances only on enabled edges. For each cycle, the model computes the expected drive flag and read word from the commands sampled two enabled edges earlier. The bench compares them half a period after every edge. Write data is drawn fresh every cycle, so a write that samples the wrong slot leaves a wrong word in memory, and a later read exposes it.

// File: rtl/sramz_pkg.sv
// Shared definitions for the zero-turnaround SRAM model.
// Assumes bursts of four beats addressed by the two low address bits.
package sramz_pkg;

    localparam int unsigned BURST_BITS = 2;

    typedef enum logic {
        ORD_INTERLEAVED = 1'b0,
        ORD_LINEAR      = 1'b1
    } burst_order_e;

    // Low address bits of a burst beat, given start bits and beat number.
    function automatic logic [BURST_BITS-1:0] burst_offset(
        input logic [BURST_BITS-1:0] start,
        input logic [BURST_BITS-1:0] beat,
        input burst_order_e          ord
    );
        logic [BURST_BITS-1:0] res;
        if (ord == ORD_LINEAR) res = start + beat;
        else                   res = start ^ beat;
        return res;
    endfunction

endpackage

// File: rtl/sramz_burst.sv
// Burst address engine: turns load/advance cycles into one command per cycle.
// Assumes AW > BURST_BITS. Stalls (cke_n_i high) freeze all state.
module sramz_burst
    import sramz_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cke_n_i,
    input  logic          adv_i,
    input  logic          sel_i,
    input  logic          rd_i,
    input  logic [AW-1:0] addr_i,
    input  logic          ord_i,
    output logic          cmd_vld_o,
    output logic          cmd_rd_o,
    output logic [AW-1:0] cmd_addr_o
);
    localparam int unsigned BB = BURST_BITS;

    logic          act_q;
    logic          rd_q;
    logic [AW-1:0] base_q;
    logic [BB-1:0] cnt_q;
    logic [BB-1:0] beat_nxt;

    assign beat_nxt = cnt_q + BB'(1);

    // Choose the command of this cycle: a fresh load or the next burst beat.
    always_comb begin
        if (!adv_i) begin
            cmd_vld_o  = sel_i;
            cmd_rd_o   = rd_i;
            cmd_addr_o = addr_i;
        end else begin
            cmd_vld_o  = act_q;
            cmd_rd_o   = rd_q;
            cmd_addr_o = {base_q[AW-1:BB],
                          burst_offset(base_q[BB-1:0], beat_nxt, burst_order_e'(ord_i))};
        end
    end

    // Track burst base, beat count and direction across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            rd_q   <= 1'b0;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (!cke_n_i) begin
            if (!adv_i) begin
                act_q  <= sel_i;
                rd_q   <= rd_i;
                base_q <= addr_i;
                cnt_q  <= '0;
            end else if (act_q) begin
                cnt_q  <= beat_nxt;
            end
        end
    end

    p_deselect_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n_i && !adv_i && !sel_i) |=> !act_q);

    p_advance_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n_i && adv_i && act_q) |=> (act_q && cnt_q == $past(cnt_q) + BB'(1)));

    p_idle_advance_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !act_q) |-> !cmd_vld_o);

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n_i |=> ($stable(act_q) && $stable(cnt_q) && $stable(base_q) && $stable(rd_q)));

endmodule

// File: rtl/sramz_pipe.sv
// Two-stage command pipeline plus registered read output.
// Assumes the array read port is combinational on rd_addr_o.
module sramz_pipe #(
    parameter int unsigned AW     = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke_n_i,
    input  logic             cmd_vld_i,
    input  logic             cmd_rd_i,
    input  logic [AW-1:0]    cmd_addr_i,
    input  logic [LANES-1:0] bw_n_i,
    input  logic [W-1:0]     rd_data_i,
    output logic             wr_en_o,
    output logic [AW-1:0]    acc_addr_o,
    output logic [LANES-1:0] wr_lanes_o,
    output logic             drv_o,
    output logic [W-1:0]     dout_o
);
    logic             s1_vld, s1_rd, s2_vld, s2_rd;
    logic [AW-1:0]    s1_addr, s2_addr;
    logic [LANES-1:0] s1_lanes, s2_lanes;
    logic             drv_q;
    logic [W-1:0]     dout_q;

    // Advance the command stages and latch read data on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_rd    <= 1'b0;
            s1_addr  <= '0;
            s1_lanes <= '0;
            s2_vld   <= 1'b0;
            s2_rd    <= 1'b0;
            s2_addr  <= '0;
            s2_lanes <= '0;
            drv_q    <= 1'b0;
            dout_q   <= '0;
        end else if (!cke_n_i) begin
            s1_vld   <= cmd_vld_i;
            s1_rd    <= cmd_rd_i;
            s1_addr  <= cmd_addr_i;
            s1_lanes <= ~bw_n_i;
            s2_vld   <= s1_vld;
            s2_rd    <= s1_rd;
            s2_addr  <= s1_addr;
            s2_lanes <= s1_lanes;
            drv_q    <= s2_vld && s2_rd;
            if (s2_vld && s2_rd) dout_q <= rd_data_i;
        end
    end

    // Present the second-stage command to the array.
    assign wr_en_o    = s2_vld && !s2_rd && !cke_n_i;
    assign acc_addr_o = s2_addr;
    assign wr_lanes_o = s2_lanes;
    assign drv_o      = drv_q;
    assign dout_o     = dout_q;

    p_read_due_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n_i && s2_vld && s2_rd) |=> drv_q);

    p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n_i && !(s2_vld && s2_rd)) |=> !drv_q);

    p_stall_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n_i |=> ($stable(drv_q) && $stable(dout_q) && $stable(s2_addr)));

endmodule

// File: rtl/sramz_array.sv
// Storage split into per-lane arrays so each lane writes independently.
// Assumes write address is below DEPTH; read port is combinational.
module sramz_array #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned AW     = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [LANES-1:0] lanes_i,
    input  logic [W-1:0]     wdata_i,
    output logic [W-1:0]     rdata_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Store this lane when its strobe was active with the command.
        always_ff @(posedge clk) begin
            if (we_i && lanes_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
        end

        assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
    end

    p_addr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (32'(addr_i) < DEPTH));

endmodule

// File: rtl/pipe_sram_zt.sv
// Top of the zero-turnaround pipelined SRAM model.
// Assumes a split data bus; dq_oe_o enables the external driver.
module pipe_sram_zt
    import sramz_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned W     = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke_n_i,
    input  logic             adv_i,
    input  logic             rw_i,
    input  logic [AW-1:0]    addr_i,
    input  logic             sel_a_n_i,
    input  logic             sel_b_i,
    input  logic             sel_c_n_i,
    input  logic [LANES-1:0] bw_n_i,
    input  logic             burst_lin_i,
    input  logic             oe_n_i,
    input  logic [W-1:0]     dq_i,
    output logic [W-1:0]     dq_o,
    output logic             dq_oe_o
);
    logic             sel_all;
    logic             cmd_vld, cmd_rd;
    logic [AW-1:0]    cmd_addr;
    logic             wr_en, drv;
    logic [AW-1:0]    acc_addr;
    logic [LANES-1:0] wr_lanes;
    logic [W-1:0]     rd_data;

    // Device is selected only when all three enables are asserted.
    assign sel_all = !sel_a_n_i && sel_b_i && !sel_c_n_i;

    sramz_burst #(.AW(AW)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke_n_i    (cke_n_i),
        .adv_i      (adv_i),
        .sel_i      (sel_all),
        .rd_i       (rw_i),
        .addr_i     (addr_i),
        .ord_i      (burst_lin_i),
        .cmd_vld_o  (cmd_vld),
        .cmd_rd_o   (cmd_rd),
        .cmd_addr_o (cmd_addr)
    );

    sramz_pipe #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke_n_i    (cke_n_i),
        .cmd_vld_i  (cmd_vld),
        .cmd_rd_i   (cmd_rd),
        .cmd_addr_i (cmd_addr),
        .bw_n_i     (bw_n_i),
        .rd_data_i  (rd_data),
        .wr_en_o    (wr_en),
        .acc_addr_o (acc_addr),
        .wr_lanes_o (wr_lanes),
        .drv_o      (drv),
        .dout_o     (dq_o)
    );

    sramz_array #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .addr_i  (acc_addr),
        .lanes_i (wr_lanes),
        .wdata_i (dq_i),
        .rdata_o (rd_data)
    );

    // Output enable gates the driver without touching the pipeline.
    assign dq_oe_o = drv && !oe_n_i;

    // Output enable high must silence the bus in the same cycle.
    always_comb begin
        p_oe_gate_r5: assert (!(oe_n_i === 1'b1 && dq_oe_o === 1'b1));
    end

    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> !dq_oe_o);

endmodule

// File: tb/tb_pipe_sram_zt.sv
module tb_pipe_sram_zt;
    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int LANES = 4;
    localparam int LW    = 9;
    localparam int W     = LANES * LW;
    localparam logic [2:0] SEL_ON = 3'b010;

    logic clk = 1'b0;
    logic rst_n, cke_n, adv, rw, sa_n, sb, sc_n, lin, oe_n;
    logic [AW-1:0] addr;
    logic [LANES-1:0] bw_n;
    logic [W-1:0] dq_i, dq_o;
    logic dq_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench model state
    logic [W-1:0] m_mem [DEPTH];
    bit m_act, m_rd;
    logic [AW-1:0] m_base;
    logic [1:0] m_cnt;
    bit s1_v, s1_r, s2_v, s2_r;
    logic [AW-1:0] s1_a, s2_a;
    logic [LANES-1:0] s1_l, s2_l;
    bit e_drv;
    logic [W-1:0] e_dout;

    always #4 clk = ~clk;

    pipe_sram_zt #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .cke_n_i(cke_n), .adv_i(adv), .rw_i(rw),
        .addr_i(addr), .sel_a_n_i(sa_n), .sel_b_i(sb), .sel_c_n_i(sc_n),
        .bw_n_i(bw_n), .burst_lin_i(lin), .oe_n_i(oe_n), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe_o(dq_oe)
    );

    function automatic logic [1:0] beat_bits(input logic [1:0] a, input logic [1:0] n, input bit linear);
        return linear ? (a + n) : (a ^ n);
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Model the effect of one clock edge, from the requirements.
    task automatic model_edge();
        bit c_v, c_r;
        logic [AW-1:0] c_a;
        if (!rst_n) begin
            m_act = 0; m_rd = 0; m_base = '0; m_cnt = '0;
            s1_v = 0; s2_v = 0; s1_r = 0; s2_r = 0; e_drv = 0;
            return;
        end
        if (cke_n) return;
        e_drv = s2_v && s2_r;
        if (e_drv) e_dout = m_mem[s2_a];
        if (s2_v && !s2_r)
            for (int k = 0; k < LANES; k++)
                if (s2_l[k]) m_mem[s2_a][k*LW +: LW] = dq_i[k*LW +: LW];
        s2_v = s1_v; s2_r = s1_r; s2_a = s1_a; s2_l = s1_l;
        if (!adv) begin
            c_v = !sa_n && sb && !sc_n; c_r = rw; c_a = addr;
            m_act = c_v; m_rd = rw; m_base = addr; m_cnt = 2'd0;
        end else begin
            c_v = m_act; c_r = m_rd;
            c_a = {m_base[AW-1:2], beat_bits(m_base[1:0], m_cnt + 2'd1, lin)};
            if (m_act) m_cnt = m_cnt + 2'd1;
        end
        s1_v = c_v; s1_r = c_r; s1_a = c_a; s1_l = ~bw_n;
    endtask

    task automatic check(input string tag);
        bit exp_oe;
        exp_oe = e_drv && !oe_n;
        n_tests++;
        if (dq_oe !== exp_oe) begin
            n_fail++;
            $display("FAIL %s dq_oe_o actual=%b expected=%b at %0t", tag, dq_oe, exp_oe, $time);
        end
        if (exp_oe) begin
            n_tests++;
            if (dq_o !== e_dout) begin
                n_fail++;
                $display("FAIL %s dq_o actual=%h expected=%h at %0t", tag, dq_o, e_dout, $time);
            end
        end
    endtask

    task automatic tick(input string tag);
        logic [63:0] r;
        r = {$urandom(), $urandom()};
        dq_i = r[W-1:0];
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag);
    endtask

    task automatic op(input bit rd, input int a, input logic [3:0] bw, input string tag);
        cke_n = 0; adv = 0; rw = rd; addr = AW'(a); {sa_n, sb, sc_n} = SEL_ON; bw_n = bw;
        tick(tag);
    endtask

    task automatic advance(input string tag);
        cke_n = 0; adv = 1; rw = 1'($urandom()); addr = AW'($urandom());
        {sa_n, sb, sc_n} = 3'($urandom()); bw_n = 4'($urandom());
        tick(tag);
    endtask

    task automatic desel(input logic [2:0] s, input string tag);
        cke_n = 0; adv = 0; rw = 1'($urandom()); addr = AW'($urandom());
        {sa_n, sb, sc_n} = s; bw_n = 4'($urandom());
        tick(tag);
    endtask

    task automatic stall(input string tag);
        cke_n = 1; adv = 1'($urandom()); rw = 1'($urandom()); addr = AW'($urandom());
        {sa_n, sb, sc_n} = 3'($urandom()); bw_n = 4'($urandom());
        tick(tag);
    endtask

    initial begin
        #(8 * 150000);
        n_tests++; n_fail++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; cke_n = 0; adv = 0; rw = 0; addr = '0; {sa_n, sb, sc_n} = 3'b110;
        bw_n = '1; lin = 1; oe_n = 0; dq_i = '0;
        for (int i = 0; i < 3; i++) tick("R11 reset");
        rst_n = 1;
        // preload every word
        for (int a = 0; a < DEPTH; a++) op(0, a, 4'b0000, "R2 preload");
        desel(3'b110, "R4 idle"); desel(3'b110, "R4 idle");
        // single read latency
        op(1, 5, 4'hF, "R1 read"); desel(3'b000, "R1 wait"); desel(3'b011, "R1 due"); desel(3'b110, "R4 release");
        // lane masked write
        op(0, 3, 4'b1010, "R2 lanes"); desel(3'b110, "R2"); op(1, 3, 4'hF, "R2 readback");
        desel(3'b110, "R2"); desel(3'b110, "R2 due"); desel(3'b110, "R2");
        // mixed traffic without gaps
        op(0, 7, 4'b0000, "R3"); op(1, 7, 4'hF, "R3"); op(0, 8, 4'b0110, "R3"); op(1, 7, 4'hF, "R3");
        op(1, 8, 4'hF, "R3"); op(0, 7, 4'b1001, "R3"); op(1, 8, 4'hF, "R3"); op(1, 7, 4'hF, "R3");
        op(0, 2, 4'b0000, "R4 write after read"); desel(3'b110, "R4"); desel(3'b110, "R4");
        // output enable override
        op(1, 2, 4'hF, "R5"); desel(3'b110, "R5"); oe_n = 1; desel(3'b110, "R5 gated");
        oe_n = 0; #1; check("R5 restored"); desel(3'b110, "R5");
        // stall in mid pipeline
        op(1, 9, 4'hF, "R6"); stall("R6 stall"); op(0, 10, 4'b0000, "R6"); stall("R6 stall");
        stall("R6 stall"); desel(3'b110, "R6"); op(1, 10, 4'hF, "R6"); stall("R6");
        desel(3'b110, "R6"); desel(3'b110, "R6"); desel(3'b110, "R6");
        // deselect ends burst, pending read completes
        lin = 1; op(1, 6, 4'hF, "R7"); advance("R7"); desel(3'b000, "R7 deselect");
        advance("R10 no burst"); advance("R10 no burst"); desel(3'b111, "R7"); desel(3'b110, "R7");
        // bursts in both orders, with wrap
        lin = 0; op(0, 9, 4'b0000, "R9 interleaved write");
        for (int i = 0; i < 5; i++) advance("R8 write beat");
        op(1, 9, 4'hF, "R9 interleaved read");
        for (int i = 0; i < 5; i++) advance("R8 read beat");
        lin = 1; op(1, 14, 4'hF, "R9 linear read");
        for (int i = 0; i < 5; i++) advance("R9 linear beat");
        desel(3'b110, "R8"); desel(3'b110, "R8"); desel(3'b110, "R8");
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int p;
            p = $urandom_range(99);
            oe_n = ($urandom_range(19) == 0);
            lin = ($urandom_range(49) == 0) ? ~lin : lin;
            if (p < 10) stall("R6 random");
            else if (p < 45) advance("R8 random");
            else if (p < 52) desel(3'($urandom() | 3'b001), "R7 random");
            else op(1'($urandom()), $urandom_range(DEPTH-1), 4'($urandom()), "R3 random");
        end
        oe_n = 0;
        desel(3'b110, "R4"); desel(3'b110, "R4"); desel(3'b110, "R4");
        summary();
    end
endmodule